// File: doc/BRIEF.md
# Binary to Radix-4 Signed-Digit Converter

This block turns a two's complement binary integer into a vector of radix-4 signed digits. Each digit is a 3-bit two's complement field that holds a value from -3 to +3. The conversion takes the magnitude of the input and cuts it into 2-bit groups. Each group becomes one digit. When the input is negative, every digit is negated. The result is sign-uniform: for a given input, all digits share the sign of that input, or are zero.

The conversion logic has no state. A parameter chooses how the result leaves the block. It can pass straight to the outputs, or it can go through one output register with an asynchronous active-low reset. Downstream carry-free adders use the digit vector as their operand format. A valid strobe travels alongside the data.

Top module: `bin2qsd_conv`

## Requirements
- R1: Every output digit is a 3-bit two's complement field with a value from -3 to +3, so the code 3'b100 never appears.
- R2: There are D = ceil(IN_W/2) digits. Digit i occupies out_digits[3*i+2:3*i] and carries weight 4^i, so the weight-1 digit sits in the lowest three bits.
- R3: The sum over all digits of digit_i * 4^i equals the signed value of the input word.
- R4: When the input's top (sign) bit is 0, every digit is 0 or positive, and digit i equals bits [2i+1:2i] of the input.
- R5: When the input's sign bit is 1, every digit is 0 or negative. Digit i is the negation of bits [2i+1:2i] of the input's magnitude.
- R6: The most negative input, -2^(IN_W-1), converts exactly. For IN_W=8 the input -128 gives digit 3 = -2 and all other digits 0.
- R7: For an odd IN_W, the top digit holds only one magnitude bit. For IN_W=7 the input -64 gives digit 3 = -1.
- R8: With REG_OUT=1, out_vld equals in_vld from one clock earlier. out_digits equals the conversion of in_word from that same clock whenever in_vld was 1.
- R9: With REG_OUT=1, an active rst_n (low) clears out_vld and all of out_digits, whatever the inputs are doing.
- R10: With REG_OUT=1, a clock with in_vld low leaves out_digits unchanged.
- R11: With REG_OUT=0, out_vld and out_digits follow in_vld and in_word in the same cycle, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input word is valid |
| in_word | input | IN_W | Two's complement binary input |
| out_vld | output | 1 | Digit vector is valid |
| out_digits | output | 3*D | Packed signed digits; digit i at [3*i+2:3*i] |

## Verification
The bench sweeps every input of an 8-bit registered instance and a 7-bit pass-through instance. For each input it computes the expected digit of every weight with arithmetic. The most negative code is the sharpest case. A design that negates in a signed width of IN_W would overflow there and produce a wrong top digit. The same overflow would also make the digit signs mixed. The odd-width sweep catches a design that splits the top group wrongly, for example by sign-extending the lone magnitude bit. The bench also checks that reset clears the register, that an invalid cycle leaves the register unchanged, and that the register adds exactly one cycle of delay. A design with a missing enable or an off-by-one stage would show a stale or early value.

// File: rtl/qsd_pkg.sv
package qsd_pkg;

    localparam int DIG_W = 3;

    typedef logic signed [DIG_W-1:0] qdigit_t;

    function automatic int digit_count(input int width);
        return (width + 1) / 2;
    endfunction

endpackage

// File: rtl/qsd_mag.sv
module qsd_mag #(
    parameter int IN_W = 8
) (
    input  logic [IN_W-1:0] word_i,
    output logic            neg_o,
    output logic [IN_W-1:0] mag_o
);

    localparam logic [IN_W-1:0] ONE = IN_W'(1);

    logic [IN_W-1:0] inverted;

    always_comb begin
        neg_o    = word_i[IN_W-1];
        inverted = ~word_i;
        // Unsigned N-bit result: the most negative code maps to 2^(N-1).
        mag_o    = neg_o ? (inverted + ONE) : word_i;
    end

endmodule

// File: rtl/qsd_digit_map.sv
module qsd_digit_map
    import qsd_pkg::*;
#(
    parameter int IN_W = 8,
    localparam int D   = digit_count(IN_W),
    localparam int PW  = 2 * D
) (
    input  logic                neg_i,
    input  logic [IN_W-1:0]     mag_i,
    output logic [DIG_W*D-1:0]  digits_o
);

    logic [PW-1:0] padded;

    assign padded = PW'(mag_i);

    for (genvar i = 0; i < D; i++) begin : g_digit
        logic [DIG_W-1:0] pos_field;
        assign pos_field = {1'b0, padded[2*i +: 2]};
        assign digits_o[DIG_W*i +: DIG_W] = neg_i ? (3'b000 - pos_field) : pos_field;
    end

endmodule

// File: rtl/qsd_out_stage.sv
module qsd_out_stage #(
    parameter int W       = 12,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_i,
    input  logic [W-1:0] data_i,
    output logic         vld_o,
    output logic [W-1:0] data_o
);

    if (REG_OUT) begin : g_reg
        logic         vld_q;
        logic [W-1:0] data_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q  <= 1'b0;
                data_q <= '0;
            end else begin
                vld_q <= vld_i;
                if (vld_i) begin
                    data_q <= data_i;
                end
            end
        end

        assign vld_o  = vld_q;
        assign data_o = data_q;
    end else begin : g_pass
        logic unused_clk_rst;
        assign unused_clk_rst = clk ^ rst_n;
        assign vld_o  = vld_i;
        assign data_o = data_i;
    end

endmodule

// File: rtl/bin2qsd_conv.sv
module bin2qsd_conv
    import qsd_pkg::*;
#(
    parameter int  IN_W    = 8,
    parameter bit  REG_OUT = 1'b1,
    localparam int D       = digit_count(IN_W),
    localparam int OUT_W   = DIG_W * D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_vld,
    input  logic [IN_W-1:0]  in_word,
    output logic             out_vld,
    output logic [OUT_W-1:0] out_digits
);

    logic             neg;
    logic [IN_W-1:0]  mag;
    logic [OUT_W-1:0] digits_c;

    qsd_mag #(.IN_W(IN_W)) u_mag (
        .word_i (in_word),
        .neg_o  (neg),
        .mag_o  (mag)
    );

    qsd_digit_map #(.IN_W(IN_W)) u_map (
        .neg_i    (neg),
        .mag_i    (mag),
        .digits_o (digits_c)
    );

    qsd_out_stage #(.W(OUT_W), .REG_OUT(REG_OUT)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (in_vld),
        .data_i (digits_c),
        .vld_o  (out_vld),
        .data_o (out_digits)
    );

endmodule

// File: rtl/qsd_conv_chk.sv
module qsd_conv_chk
    import qsd_pkg::*;
#(
    parameter int  IN_W    = 8,
    parameter bit  REG_OUT = 1'b1,
    localparam int D       = digit_count(IN_W),
    localparam int OUT_W   = DIG_W * D
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_vld,
    input logic [IN_W-1:0]  in_word,
    input logic             out_vld,
    input logic [OUT_W-1:0] out_digits
);

    function automatic longint rebuild(input logic [OUT_W-1:0] v);
        longint acc = 0;
        for (int i = D - 1; i >= 0; i--) begin
            acc = acc * 4 + longint'($signed(v[DIG_W*i +: DIG_W]));
        end
        return acc;
    endfunction

    logic any_pos, any_neg, past_ok;

    always_comb begin
        any_pos = 1'b0;
        any_neg = 1'b0;
        for (int i = 0; i < D; i++) begin
            if (out_digits[DIG_W*i + 2]) any_neg = 1'b1;
            else if (out_digits[DIG_W*i +: 2] != 2'b00) any_pos = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    for (genvar i = 0; i < D; i++) begin : g_rng
        AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            out_digits[DIG_W*i +: DIG_W] != 3'b100); // R1
    end

    AST_SIGN_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        !(any_pos && any_neg)); // R4

    if (REG_OUT) begin : g_reg_chk
        AST_VLD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok |-> out_vld == $past(in_vld)); // R8
        AST_VALUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && $past(in_vld) |->
                rebuild(out_digits) == longint'($signed($past(in_word)))); // R3
        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok && !$past(in_vld) |-> $stable(out_digits)); // R10
    end else begin : g_comb_chk
        AST_VALUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            in_vld |-> rebuild(out_digits) == longint'($signed(in_word))); // R11
    end

endmodule

bind bin2qsd_conv qsd_conv_chk #(.IN_W(IN_W), .REG_OUT(REG_OUT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_vld     (in_vld),
    .in_word    (in_word),
    .out_vld    (out_vld),
    .out_digits (out_digits)
);

// File: tb/sim_bin2qsd_conv.sv
module sim_bin2qsd_conv;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld0 = 1'b0, vld1 = 1'b0;
    logic [7:0]  w0 = '0;
    logic [6:0]  w1 = '0;
    logic        ov0, ov1;
    logic [11:0] od0, od1;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    bin2qsd_conv #(.IN_W(8), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(vld0), .in_word(w0),
        .out_vld(ov0), .out_digits(od0)
    );

    bin2qsd_conv #(.IN_W(7), .REG_OUT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .in_vld(vld1), .in_word(w1),
        .out_vld(ov1), .out_digits(od1)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int dig(input logic [11:0] v, input int i);
        return int'($signed(v[3*i +: 3]));
    endfunction

    // Compare all four digits against arithmetic expectation and value rebuild.
    task automatic check_vec(input logic [11:0] v, input int x, input string tag);
        int mag = (x < 0) ? -x : x;
        longint sum = 0;
        bit pos = 0, neg = 0;
        for (int i = 0; i < 4; i++) begin
            int e = (mag >> (2 * i)) & 3;
            int d = dig(v, i);
            if (x < 0) e = -e;
            chk(v[3*i +: 3] != 3'b100, {tag, " R1 range"}, d, e);
            chk(d == e, {tag, (x < 0) ? " R5 digit" : " R4 digit", " R2"}, d, e);
            if (d > 0) pos = 1;
            if (d < 0) neg = 1;
            sum += longint'(d) << (2 * i);
        end
        chk(sum == x, {tag, " R3 rebuild"}, sum, x);
        chk(!(x >= 0 && neg) && !(x < 0 && pos), {tag, " R4/R5 sign"}, {pos, neg}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R9: reset holds outputs clear while inputs are active
        vld0 = 1'b1; w0 = 8'h5A;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ov0 == 1'b0, "R9 reset valid", ov0, 0);
        chk(od0 == '0, "R9 reset digits", od0, 0);
        rst_n = 1'b1;
        vld0 = 1'b0;
        @(negedge clk);

        // R8: one-cycle latency on valid and data
        vld0 = 1'b1; w0 = 8'd27;
        #1 chk(ov0 == 1'b0, "R8 no early valid", ov0, 0);
        @(negedge clk);
        chk(ov0 == 1'b1, "R8 valid latency", ov0, 1);
        check_vec(od0, 27, "u0");

        // Exhaustive sweep of the registered 8-bit instance
        for (int x = -128; x < 128; x++) begin
            vld0 = 1'b1; w0 = 8'(x);
            @(negedge clk);
            check_vec(od0, x, "u0");
        end

        // R6: most negative code
        vld0 = 1'b1; w0 = 8'h80;
        @(negedge clk);
        chk(dig(od0, 3) == -2 && od0[8:0] == '0, "R6 min value", dig(od0, 3), -2);

        // R10: invalid cycle holds digits
        vld0 = 1'b0; w0 = 8'd99;
        @(negedge clk);
        chk(ov0 == 1'b0, "R10 valid low", ov0, 0);
        chk(dig(od0, 3) == -2 && od0[8:0] == '0, "R10 hold digits", dig(od0, 3), -2);

        // Exhaustive sweep of the pass-through 7-bit instance (R11)
        for (int x = -64; x < 64; x++) begin
            vld1 = 1'b1; w1 = 7'(x);
            #1;
            chk(ov1 == 1'b1, "R11 valid same cycle", ov1, 1);
            check_vec(od1, x, "u1 R11");
            #1;
        end
        vld1 = 1'b0;
        #1 chk(ov1 == 1'b0, "R11 valid drop", ov1, 0);

        // R7: odd width top digit
        vld1 = 1'b1; w1 = 7'h40;
        #1 chk(dig(od1, 3) == -1 && od1[8:0] == '0, "R7 odd top digit", dig(od1, 3), -1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule